// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic core of a small 8-bit accumulator processor. It is purely combinational. It takes the accumulator value, one operand byte, the current flag byte and a 3-bit operation select. It returns the next accumulator value and the next flag byte. The eight byte operations are add, add with carry, subtract, subtract with borrow, the three bitwise operations and compare.

A second path adds a 16-bit register pair to a 16-bit address register. It is selected with `wideMode`. In that mode the accumulator passes through unchanged and the flag byte follows the wide-add rules.

The surrounding core does the rest. It fetches the operands, decodes the instruction into `opSel`/`wideMode`, and writes `accOut`, `addrOut` and `flagsOut` back into its own registers.

Top module: `acc_alu`

## Requirements
- R1: The flag byte places zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4. Bits 3..0 of `flagsOut` are always 0, whatever `flagsIn` holds.
- R2: `opSel` codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR and 7 compare. For add, `accOut` is the low byte of acc+operand and carry is the carry out of bit 7.
- R3: For the four arithmetic byte operations and compare, half-carry equals bit 4 of (acc XOR operand XOR 8-bit result), and zero is set exactly when the 8-bit result is 0.
- R4: Add-with-carry adds the incoming carry flag (`flagsIn` bit 4) as an extra 1. Subtract-with-borrow subtracts it as an extra 1. Plain add, subtract and compare ignore it.
- R5: Subtract, subtract-with-borrow and compare always set the subtract flag and set carry when a borrow leaves bit 7. Add and add-with-carry clear the subtract flag.
- R6: Compare produces the subtract flags for acc−operand but leaves `accOut` equal to `accIn`.
- R7: AND writes acc AND operand, sets half-carry, clears subtract and carry, and sets zero from the result.
- R8: XOR and OR write their result and clear every flag except zero, which follows the result.
- R9: With `wideMode`=1, `addrOut` = (addrIn+pairIn) mod 2^16. Zero is copied from `flagsIn` bit 7, subtract is cleared, half-carry is the carry out of bit 11 and carry is the carry out of bit 15.
- R10: With `wideMode`=1, `accOut` equals `accIn` for every `opSel`. With `wideMode`=0, `addrOut` equals `addrIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| accIn | input | 8 | Current accumulator |
| operand | input | 8 | Second byte operand |
| flagsIn | input | 8 | Current flag byte |
| opSel | input | 3 | Byte operation select |
| wideMode | input | 1 | Select the 16-bit address add path |
| addrIn | input | 16 | Current address register |
| pairIn | input | 16 | Register pair added to the address |
| accOut | output | 8 | Next accumulator |
| flagsOut | output | 8 | Next flag byte |
| addrOut | output | 16 | Next address register |

## Verification
The block holds no state, so every fault shows at the ports in the same evaluation that the inputs change. Typical faults are a mis-decoded strobe (carry not folded in, subtract not inverted, compare writing the result) or a wrong carry tap. The bench compares all eight byte operations, both carry-in values, every accumulator value and a spread of operands against a reference written from the requirements. Directed cases then pin the wrap-around, borrow, nibble-boundary and flag-preservation corners, where a single wrong bit is most likely to hide.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  // Flag bit positions: the core decodes these, so they are fixed.
  localparam int ZERO_BIT  = 7;
  localparam int SUB_BIT   = 6;
  localparam int HALF_BIT  = 5;
  localparam int CARRY_BIT = 4;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } aluOp_t;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_XOR = 2'd1,
    LOG_OR  = 2'd2
  } logicKind_t;

  typedef struct packed {
    logic       isArith;   // adder result drives the accumulator path
    logic       subMode;   // invert operand, borrow semantics
    logic       useCarry;  // fold incoming carry flag in
    logic       writeAcc;  // result replaces the accumulator
    logic       wide;      // 16-bit address add selected
    logicKind_t logicKind; // which bitwise function
  } aluStrobes_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic [2:0]  opSel,
  input  logic        wideMode,
  output aluStrobes_t strobes
);

  aluOp_t opCode;
  assign opCode = aluOp_t'(opSel);

  always_comb begin
    strobes           = '0;
    strobes.wide      = wideMode;
    strobes.logicKind = LOG_AND;
    unique case (opCode)
      OP_ADD: begin strobes.isArith = 1'b1; strobes.writeAcc = 1'b1; end
      OP_ADC: begin strobes.isArith = 1'b1; strobes.useCarry = 1'b1; strobes.writeAcc = 1'b1; end
      OP_SUB: begin strobes.isArith = 1'b1; strobes.subMode = 1'b1; strobes.writeAcc = 1'b1; end
      OP_SBC: begin strobes.isArith = 1'b1; strobes.subMode = 1'b1; strobes.useCarry = 1'b1;
                    strobes.writeAcc = 1'b1; end
      OP_AND: begin strobes.logicKind = LOG_AND; strobes.writeAcc = 1'b1; end
      OP_XOR: begin strobes.logicKind = LOG_XOR; strobes.writeAcc = 1'b1; end
      OP_OR:  begin strobes.logicKind = LOG_OR;  strobes.writeAcc = 1'b1; end
      OP_CMP: begin strobes.isArith = 1'b1; strobes.subMode = 1'b1; end
      default: strobes.isArith = 1'b0;
    endcase
    // The wide path never touches the accumulator.
    if (wideMode) strobes.writeAcc = 1'b0;
  end

  // Compare and wide add never write the accumulator (R6, R10)
  always_comb begin
    if (opCode == OP_CMP || wideMode)
      p_no_acc_write_r6: assert (!strobes.writeAcc)
        else $error("accumulator write enabled for compare or wide add");
  end

endmodule

// File: rtl/acc_alu_dpath.sv
module acc_alu_dpath
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
)(
  input  aluStrobes_t       strobes,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic [7:0]        flagsIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [ADDR_W-1:0] pairIn,
  output logic [DATA_W-1:0] accOut,
  output logic [7:0]        flagsOut,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int BYTE_HALF = DATA_W / 2;  // nibble boundary for half-carry
  localparam int WIDE_HALF = ADDR_W - 4;  // carry out of bit 11 for 16 bits

  // ---------------- byte adder ----------------
  logic              carryIn;
  logic              cinEff;
  logic [DATA_W-1:0] opEff;
  logic [DATA_W:0]   byteSum;
  logic [DATA_W-1:0] arithRes;
  logic              arithCarry;
  logic              arithHalf;

  always_comb begin
    carryIn    = strobes.useCarry & flagsIn[CARRY_BIT];
    opEff      = strobes.subMode ? ~operand : operand;
    cinEff     = strobes.subMode ? ~carryIn : carryIn;
    byteSum    = {1'b0, accIn} + {1'b0, opEff} + {{DATA_W{1'b0}}, cinEff};
    arithRes   = byteSum[DATA_W-1:0];
    arithCarry = strobes.subMode ? ~byteSum[DATA_W] : byteSum[DATA_W];
    arithHalf  = accIn[BYTE_HALF] ^ operand[BYTE_HALF] ^ arithRes[BYTE_HALF];
  end

  // ---------------- bitwise unit ----------------
  logic [DATA_W-1:0] logicRes;

  always_comb begin
    unique case (strobes.logicKind)
      LOG_AND: logicRes = accIn & operand;
      LOG_XOR: logicRes = accIn ^ operand;
      LOG_OR:  logicRes = accIn | operand;
      default: logicRes = accIn & operand;
    endcase
  end

  // ---------------- wide adder ----------------
  logic [ADDR_W:0] wideSum;
  logic            wideHalf;

  always_comb begin
    wideSum  = {1'b0, addrIn} + {1'b0, pairIn};
    wideHalf = addrIn[WIDE_HALF] ^ pairIn[WIDE_HALF] ^ wideSum[WIDE_HALF];
  end

  // ---------------- result and flag merge ----------------
  logic [DATA_W-1:0] byteRes;

  always_comb begin
    byteRes  = strobes.isArith ? arithRes : logicRes;
    flagsOut = '0;
    accOut   = strobes.writeAcc ? byteRes : accIn;
    addrOut  = strobes.wide ? wideSum[ADDR_W-1:0] : addrIn;
    if (strobes.wide) begin
      flagsOut[ZERO_BIT]  = flagsIn[ZERO_BIT];
      flagsOut[HALF_BIT]  = wideHalf;
      flagsOut[CARRY_BIT] = wideSum[ADDR_W];
    end else if (strobes.isArith) begin
      flagsOut[ZERO_BIT]  = (arithRes == '0);
      flagsOut[SUB_BIT]   = strobes.subMode;
      flagsOut[HALF_BIT]  = arithHalf;
      flagsOut[CARRY_BIT] = arithCarry;
    end else begin
      flagsOut[ZERO_BIT]  = (logicRes == '0);
      flagsOut[HALF_BIT]  = (strobes.logicKind == LOG_AND);
    end
  end

  // ---------------- local checks ----------------
  always_comb begin
    p_low_zero_r1: assert (flagsOut[3:0] == 4'h0)
      else $error("low flag bits not zero");
    if (strobes.wide)
      p_wide_flags_r9: assert (flagsOut[ZERO_BIT] == flagsIn[ZERO_BIT] && !flagsOut[SUB_BIT])
        else $error("wide add disturbed zero or subtract flag");
    if (!strobes.wide && !strobes.isArith)
      p_logic_carry_r8: assert (!flagsOut[CARRY_BIT] && !flagsOut[SUB_BIT])
        else $error("bitwise op left carry or subtract set");
    if (!strobes.wide && strobes.isArith)
      p_sub_flag_r5: assert (flagsOut[SUB_BIT] == strobes.subMode)
        else $error("subtract flag mismatch");
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic [7:0]  accIn,
  input  logic [7:0]  operand,
  input  logic [7:0]  flagsIn,
  input  logic [2:0]  opSel,
  input  logic        wideMode,
  input  logic [15:0] addrIn,
  input  logic [15:0] pairIn,
  output logic [7:0]  accOut,
  output logic [7:0]  flagsOut,
  output logic [15:0] addrOut
);

  aluStrobes_t strobes;

  acc_alu_ctrl u_ctrl (
    .opSel    (opSel),
    .wideMode (wideMode),
    .strobes  (strobes)
  );

  acc_alu_dpath #(.DATA_W(8), .ADDR_W(16)) u_dpath (
    .strobes  (strobes),
    .accIn    (accIn),
    .operand  (operand),
    .flagsIn  (flagsIn),
    .addrIn   (addrIn),
    .pairIn   (pairIn),
    .accOut   (accOut),
    .flagsOut (flagsOut),
    .addrOut  (addrOut)
  );

  always_comb begin
    if (wideMode || opSel == 3'd7)
      p_acc_hold_r10: assert (accOut == accIn)
        else $error("accumulator changed on compare or wide add");
    if (!wideMode && opSel == 3'd4)
      p_and_flags_r7: assert (flagsOut[HALF_BIT] && !flagsOut[CARRY_BIT])
        else $error("AND flags wrong");
  end

endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/100ps
module sim_acc_alu;

  localparam real CLK_HALF = 2.5;  // 200 MHz

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  accIn = '0, operand = '0, flagsIn = '0;
  logic [2:0]  opSel = '0;
  logic        wideMode = 1'b0;
  logic [15:0] addrIn = '0, pairIn = '0;
  logic [7:0]  accOut, flagsOut;
  logic [15:0] addrOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  acc_alu u0 (
    .accIn(accIn), .operand(operand), .flagsIn(flagsIn), .opSel(opSel),
    .wideMode(wideMode), .addrIn(addrIn), .pairIn(pairIn),
    .accOut(accOut), .flagsOut(flagsOut), .addrOut(addrOut)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // Reference model written from the requirements (integer arithmetic).
  task automatic refByte(input int op, input int a, input int b, input int fin,
                         output int res, output int flg);
    int ci, r, z, n, h, c;
    ci = (fin >> 4) & 1;
    n = 0; h = 0; c = 0;
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        r = a + b + ci;
        h = (((a & 15) + (b & 15) + ci) > 15) ? 1 : 0;
        c = (r > 255) ? 1 : 0;
      end
      2, 3, 7: begin
        if (op != 3) ci = 0;
        r = a - b - ci;
        h = (((a & 15) - (b & 15) - ci) < 0) ? 1 : 0;
        c = (r < 0) ? 1 : 0;
        n = 1;
      end
      4: begin r = a & b; h = 1; end
      5: r = a ^ b;
      default: r = a | b;
    endcase
    r = r & 255;
    z = (r == 0) ? 1 : 0;
    flg = (z << 7) | (n << 6) | (h << 5) | (c << 4);
    res = (op == 7) ? a : r;
  endtask

  task automatic applyByte(input int op, input int a, input int b, input int fin);
    @(negedge clk);
    wideMode = 1'b0; opSel = 3'(op);
    accIn = 8'(a); operand = 8'(b); flagsIn = 8'(fin);
    #1;
  endtask

  task automatic testReset;
    // R1: quiet inputs give zero flags with low nibble clear
    applyByte(0, 0, 0, 8'h0F);
    check("R1 reset flags", flagsOut, 8'h80);
    check("R10 addr passthrough", addrOut, 16'h0000);
  endtask

  task automatic testAddCorners;
    applyByte(0, 8'hFF, 8'h01, 8'h0F);
    check("R2 add wrap acc", accOut, 8'h00);
    check("R3 add wrap flags", flagsOut, 8'hB0);
    applyByte(0, 8'h0F, 8'h00, 8'h10);
    check("R4 add ignores carry", flagsOut, 8'h00);
    applyByte(1, 8'h0F, 8'h00, 8'h10);
    check("R4 adc acc", accOut, 8'h10);
    check("R4 adc flags", flagsOut, 8'h20);
  endtask

  task automatic testSubCorners;
    applyByte(2, 8'h10, 8'h01, 8'h00);
    check("R5 sub acc", accOut, 8'h0F);
    check("R5 sub flags", flagsOut, 8'h60);
    applyByte(3, 8'h00, 8'h00, 8'h10);
    check("R4 sbc acc", accOut, 8'hFF);
    check("R5 sbc borrow flags", flagsOut, 8'h70);
    applyByte(7, 8'h05, 8'h05, 8'h10);
    check("R6 cmp acc kept", accOut, 8'h05);
    check("R6 cmp flags", flagsOut, 8'hC0);
  endtask

  task automatic testLogic;
    applyByte(4, 8'hF0, 8'h0F, 8'hFF);
    check("R7 and acc", accOut, 8'h00);
    check("R7 and flags", flagsOut, 8'hA0);
    applyByte(5, 8'h5A, 8'h5A, 8'hFF);
    check("R8 xor flags", flagsOut, 8'h80);
    applyByte(6, 8'h01, 8'h00, 8'hFF);
    check("R8 or acc", accOut, 8'h01);
    check("R8 or flags", flagsOut, 8'h00);
  endtask

  task automatic testWide;
    @(negedge clk);
    wideMode = 1'b1; opSel = 3'd2; accIn = 8'h3C; operand = 8'h11;
    addrIn = 16'h0FFF; pairIn = 16'h0001; flagsIn = 8'h80;
    #1;
    check("R9 wide sum", addrOut, 16'h1000);
    check("R9 wide half", flagsOut, 8'hA0);
    check("R10 wide acc kept", accOut, 8'h3C);
    @(negedge clk);
    addrIn = 16'hFFFF; pairIn = 16'h0001; flagsIn = 8'h4F;
    #1;
    check("R9 wide wrap sum", addrOut, 16'h0000);
    check("R9 wide wrap flags", flagsOut, 8'h30);
    @(negedge clk);
    addrIn = 16'h8000; pairIn = 16'h8000; flagsIn = 8'hF0;
    #1;
    check("R9 wide carry only", flagsOut, 8'h90);
    @(negedge clk);
    wideMode = 1'b0; opSel = 3'd0;
    #1;
    check("R10 addr held byte mode", addrOut, 16'h8000);
  endtask

  task automatic testSweep;
    int res, flg;
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 17)
          for (int ci = 0; ci < 2; ci++) begin
            refByte(op, a, b, ci << 4 | 8'h0F, res, flg);
            wideMode = 1'b0; opSel = 3'(op);
            accIn = 8'(a); operand = 8'(b); flagsIn = 8'((ci << 4) | 8'h0F);
            #0.2;
            check("R2 R3 R4 sweep acc", accOut, res);
            check("R5 R7 R8 sweep flags", flagsOut, flg);
          end
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        rstN = 1'b1;
        testReset();
        testAddCorners();
        testSubCorners();
        testLogic();
        testWide();
        testSweep();
        done = 1'b1;
      end
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule